// File: doc/BRIEF.md
# Supervisory Watchdog Timer with Failsafe Boot Select

This block is a watchdog timer for a board management controller. It counts down whole seconds from a programmed period. When the count runs out, it can raise a system reset pulse and pull a separate active-low timeout line. If the failsafe enable was the active one, it also latches a flag that tells the next boot to take the failsafe loader. A prescaler divides the system clock into a one-second tick.

Software reaches the block through a small byte-wide port with an address, write data, a write strobe and a read strobe. There are three registers:

- **Control** (address 0): holds the two run enables, a sticky lock and the two output selects.
- **Period** (address 1): holds the timeout in seconds.
- **Kick** (address 2): a write of the key value reloads the counter.

A strap input decides whether the watchdog starts by itself after hardware reset. Boot software normally leaves it running through startup and turns it off once startup has succeeded.

Top module: `board_wdt`

## Requirements
- R1: After hardware reset with the strap low, sys_rst_o is 0, wdt_out_n_o is 1 and failsafe_o is 0. Control reads 0x00, the period reads DEF_TIMEOUT, and no expiry occurs.
- R2: With boot_en_i high, control is loaded with 0x41 (normal run, reset output enabled) on the first clock after reset is released. The counter starts from DEF_TIMEOUT, so expiry follows DEF_TIMEOUT*CLK_PER_SEC+1 cycles after that clock.
- R3: A write of 0x6B to address 2 reloads both the counter and the prescaler. Expiry comes T*CLK_PER_SEC+1 cycles after the enabling write or the last kick, whichever is later, where T is the period.
- R4: A write of any other value to address 2 has no effect on the countdown.
- R5: When control bits 1:0 are both clear, the counter stops and no expiry occurs.
- R6: With a period of 0, a kick and then a write that sets an enable make the block expire on the next clock.
- R7: On expiry with control bit 6 set, sys_rst_o goes high for exactly PULSE_LEN cycles. With bit 6 clear, it stays low.
- R8: On expiry with control bit 7 set, wdt_out_n_o goes low and stays low until rst_ni. With bit 7 clear, it stays high.
- R9: On expiry with control bit 1 (failsafe run) set, failsafe_o goes high and stays high until rst_ni. An expiry under bit 0 (normal run) leaves it low.
- R10: Once control bit 2 is set, writes to control are ignored until rst_ni. Kicks still work while the lock is set.
- R11: Reads return the current control value, with bits 5:3 always 0. Address 1 returns the period, and addresses 2 and 3 return 0.
- R12: Expiry clears control bits 1:0 and leaves the other control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| boot_en_i | input | 1 | Strap: start the watchdog after reset |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data (combinational) |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| wdt_out_n_o | output | 1 | Active-low sticky timeout line |
| failsafe_o | output | 1 | Sticky failsafe boot select |

## Verification
The bench checks expiry to the exact cycle, from both sides of the boundary. A design with an off-by-one in the prescaler, or with a kick that fails to clear the prescaler, would fire one tick early or late.

A period of zero must fire on the very next clock. A design that waits for a tick first would lag by a whole second.

The bench also covers:
- kicks with a wrong key, which must not reload;
- a write to a locked control register, which must not disable the watchdog;
- disabling mid-count, which must not still fire;
- the failsafe flag, which must outlast the reset pulse.

Random periods and control patterns cross the three output selects with both run modes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_TMO  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_KICK = 2'd2;

  localparam int B_NORM  = 0;
  localparam int B_RECOV = 1;
  localparam int B_LOCK  = 2;
  localparam int B_RSTEN = 6;
  localparam int B_TMOEN = 7;

  localparam logic [REG_W-1:0] KICK_KEY   = 8'h6B;
  localparam logic [REG_W-1:0] CTRL_MASK  = 8'hC7;
  localparam logic [REG_W-1:0] CTRL_STRAP = 8'h41;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (!run_i || clr_i)    pre_q <= '0;
    else if (pre_q == LAST)      pre_q <= '0;
    else                         pre_q <= pre_q + W'(1);
  end

  assign tick_o = run_i && !clr_i && (pre_q == LAST);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_TIMEOUT = 8'd30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              expire_i,
  output logic [REG_W-1:0]  ctrl_o,
  output logic [REG_W-1:0]  tmo_o,
  output logic              kick_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [REG_W-1:0] ctrl_q, tmo_q;
  logic             init_q;

  // strap is sampled on the first clock after reset, not as an async reset value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tmo_q  <= DEF_TIMEOUT;
      init_q <= 1'b0;
    end else if (!init_q) begin
      init_q <= 1'b1;
      ctrl_q <= strap_i ? CTRL_STRAP : '0;
    end else begin
      if (wr_i && addr_i == ADR_CTRL && !ctrl_q[B_LOCK]) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_i && addr_i == ADR_TMO) tmo_q <= wdata_i;
      if (expire_i) begin
        ctrl_q[B_NORM]  <= 1'b0;
        ctrl_q[B_RECOV] <= 1'b0;
      end
    end
  end

  assign kick_o = init_q && wr_i && (addr_i == ADR_KICK) && (wdata_i == KICK_KEY);
  assign ctrl_o = ctrl_q;
  assign tmo_o  = tmo_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        ADR_CTRL: rdata_o = ctrl_q;
        ADR_TMO:  rdata_o = tmo_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_TIMEOUT = 8'd30,
  parameter int               PULSE_LEN   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [REG_W-1:0] tmo_i,
  input  logic             rst_en_i,
  input  logic             tmo_en_i,
  input  logic             recov_i,
  output logic             expire_o,
  output logic             sys_rst_o,
  output logic             tmo_n_o,
  output logic             failsafe_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [REG_W-1:0] cnt_q;
  logic [PW-1:0]    pulse_q;
  logic             tmo_n_q, fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= DEF_TIMEOUT;
    else if (kick_i)                          cnt_q <= tmo_i;
    else if (run_i && tick_i && cnt_q != '0)  cnt_q <= cnt_q - REG_W'(1);
  end

  // zero count fires without waiting for a tick
  assign expire_o = run_i && (cnt_q == '0) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      tmo_n_q <= 1'b1;
      fs_q    <= 1'b0;
    end else begin
      if (expire_o && rst_en_i) pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0)   pulse_q <= pulse_q - PW'(1);
      if (expire_o && tmo_en_i) tmo_n_q <= 1'b0;
      if (expire_o && recov_i)  fs_q    <= 1'b1;
    end
  end

  assign sys_rst_o  = (pulse_q != '0);
  assign tmo_n_o    = tmo_n_q;
  assign failsafe_o = fs_q;
endmodule

// File: rtl/board_wdt.sv
module board_wdt
  import wdt_pkg::*;
#(
  parameter int               CLK_PER_SEC = 1000,
  parameter int               PULSE_LEN   = 16,
  parameter logic [REG_W-1:0] DEF_TIMEOUT = 8'd30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              sys_rst_o,
  output logic              wdt_out_n_o,
  output logic              failsafe_o
);
  logic [REG_W-1:0] ctrl, tmo;
  logic             kick, expire, tick, run;

  wdt_regs #(.DEF_TIMEOUT(DEF_TIMEOUT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (boot_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .expire_i (expire),
    .ctrl_o   (ctrl),
    .tmo_o    (tmo),
    .kick_o   (kick),
    .rdata_o  (rdata_o)
  );

  assign run = ctrl[B_NORM] | ctrl[B_RECOV];

  wdt_prescale #(.DIV(CLK_PER_SEC)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (kick),
    .tick_o (tick)
  );

  wdt_core #(.DEF_TIMEOUT(DEF_TIMEOUT), .PULSE_LEN(PULSE_LEN)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .kick_i     (kick),
    .tmo_i      (tmo),
    .rst_en_i   (ctrl[B_RSTEN]),
    .tmo_en_i   (ctrl[B_TMOEN]),
    .recov_i    (ctrl[B_RECOV]),
    .expire_o   (expire),
    .sys_rst_o  (sys_rst_o),
    .tmo_n_o    (wdt_out_n_o),
    .failsafe_o (failsafe_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       sys_rst_o,
  input logic       wdt_out_n_o,
  input logic       failsafe_o,
  input logic [7:0] ctrl_i,
  input logic       expire_i
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + 16'd1;
    else                hi_cnt <= '0;
  end

  p_pulse_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (hi_cnt < 16'(PULSE_LEN)));
  p_pulse_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(expire_i));
  p_tmo_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_out_n_o |=> !wdt_out_n_o);
  p_fs_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    failsafe_o |=> failsafe_o);
  p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[2] |=> ctrl_i[2]);
  p_kick_rd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd2) |-> (rdata_o == 8'h00));
  p_expire_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (ctrl_i[1:0] == 2'b00));
endmodule

bind board_wdt wdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .sys_rst_o   (sys_rst_o),
  .wdt_out_n_o (wdt_out_n_o),
  .failsafe_o  (failsafe_o),
  .ctrl_i      (ctrl),
  .expire_i    (expire)
);

// File: tb/tb_board_wdt.sv
module tb_board_wdt;
  localparam int         P   = 4;
  localparam int         LEN = 3;
  localparam logic [7:0] DEF = 8'd2;

  logic       clk = 1'b0, rst_ni = 1'b0, strap = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sys_rst, tmo_n, fs;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  board_wdt #(.CLK_PER_SEC(P), .PULSE_LEN(LEN), .DEF_TIMEOUT(DEF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .boot_en_i(strap), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .sys_rst_o(sys_rst), .wdt_out_n_o(tmo_n), .failsafe_o(fs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic hw_reset(logic s);
    strap = s; rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic arm(logic [7:0] t, logic [7:0] c);
    wr_reg(2'd1, t);
    wr_reg(2'd2, 8'h6B);
    wr_reg(2'd0, c);
  endtask

  function automatic logic [7:0] ctrl_after(logic [7:0] c);
    return c & 8'hC4;
  endfunction

  task automatic idle(string req);
    chk(req, {sys_rst, tmo_n}, 2'b01);
  endtask

  task automatic trial(logic [7:0] t, logic [7:0] c);
    logic [7:0] r;
    hw_reset(1'b0);
    arm(t, c);
    if (t != 0) begin
      step(int'(t) * P);
      idle("R3 before expiry");
    end
    step(1);
    chk("R7 reset select", sys_rst, c[6]);
    chk("R8 line select", tmo_n, !c[7]);
    chk("R9 failsafe select", fs, c[1]);
    if (c[6]) begin
      step(LEN - 1);
      chk("R7 pulse still high", sys_rst, 1'b1);
      step(1);
      chk("R7 pulse ended", sys_rst, 1'b0);
    end
    step(4);
    chk("R9 failsafe held", fs, c[1]);
    chk("R8 line held", tmo_n, !c[7]);
    rd_reg(2'd0, r);
    chk("R12 R11 ctrl after expiry", r, ctrl_after(c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5a17));

    // R1 reset state
    hw_reset(1'b0);
    chk("R1 outputs", {sys_rst, tmo_n, fs}, 3'b010);
    rd_reg(2'd0, r); chk("R1 ctrl", r, 8'h00);
    rd_reg(2'd1, r); chk("R1 period", r, DEF);
    rd_reg(2'd2, r); chk("R11 kick reads 0", r, 8'h00);
    step(40);
    idle("R1 no expiry");

    // R2 strap start
    hw_reset(1'b1);
    rd_reg(2'd0, r); chk("R2 strap ctrl", r, 8'h41);
    step(int'(DEF) * P);
    idle("R2 before expiry");
    step(1);
    chk("R2 expiry", sys_rst, 1'b1);

    // R3 kick reload mid-count
    hw_reset(1'b0);
    arm(8'd2, 8'h41);
    step(6);
    wr_reg(2'd2, 8'h6B);
    step(2 * P);
    idle("R3 kick reloaded");
    step(1);
    chk("R3 expiry after kick", sys_rst, 1'b1);

    // R4 wrong key
    hw_reset(1'b0);
    arm(8'd2, 8'h41);
    step(6);
    wr_reg(2'd2, 8'h6A);
    step(1);
    idle("R4 before original expiry");
    step(1);
    chk("R4 wrong key ignored", sys_rst, 1'b1);

    // R5 stop
    hw_reset(1'b0);
    arm(8'd1, 8'h41);
    step(2);
    wr_reg(2'd0, 8'h40);
    step(30);
    idle("R5 stopped");
    rd_reg(2'd0, r); chk("R5 ctrl", r, 8'h40);

    // R6 zero period
    hw_reset(1'b0);
    arm(8'd0, 8'hC1);
    step(1);
    chk("R6 instant expiry", {sys_rst, tmo_n}, 2'b10);

    // R10 lock
    hw_reset(1'b0);
    wr_reg(2'd1, 8'd2);
    wr_reg(2'd2, 8'h6B);
    wr_reg(2'd0, 8'h45);
    wr_reg(2'd0, 8'h00);
    rd_reg(2'd0, r); chk("R10 locked write ignored", r, 8'h45);
    wr_reg(2'd2, 8'h6B);
    step(2 * P);
    idle("R10 kick under lock");
    step(1);
    chk("R10 expiry while locked", sys_rst, 1'b1);
    rd_reg(2'd0, r); chk("R12 lock kept", r, 8'h44);

    // R11 period readback
    wr_reg(2'd1, 8'hA5);
    rd_reg(2'd1, r); chk("R11 period read", r, 8'hA5);
    rd_reg(2'd3, r); chk("R11 addr3 read", r, 8'h00);

    // R8 R9 cleared only by hardware reset
    trial(8'd1, 8'h82);
    step(20);
    chk("R8 line sticky", tmo_n, 1'b0);
    chk("R9 flag sticky", fs, 1'b1);
    hw_reset(1'b0);
    chk("R8 R9 cleared by reset", {tmo_n, fs}, 2'b10);

    // directed: normal mode never selects failsafe
    trial(8'd1, 8'hC1);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] t, c;
      t = 8'($urandom_range(0, 4));
      c = 8'($urandom) & 8'hFC;
      c[1:0] = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
      trial(t, c);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule